// File: doc/BRIEF.md
# Nine-Bit ROM Bank Controller

This block sits between a CPU's 16-bit address bus and an external ROM and RAM on a cartridge. It turns CPU writes in the low part of the address space into control updates: a RAM enable, a 9-bit ROM bank number and a 4-bit RAM bank number. The ROM bank number is written in two parts, a low byte and a top bit, through two separate address ranges. CPU reads in the fixed ROM window, the switchable ROM window and the RAM window are turned into physical addresses for the external arrays.

Each access takes a single cycle. The address, strobe and zero-data outputs are combinational from the CPU inputs and the control registers. Control writes take effect at the rising clock edge that samples the write strobe. When an access would land outside the configured memory, the block raises a zero-data flag instead of a memory strobe, and the data path then returns zero. The ROM bank count, the RAM bank count and whether RAM exists at all are parameters.

Top module: `bank9_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0 and RAM is disabled.
- R2: A write to 0x0000–0x1FFF enables RAM when the data byte is 0x0A. Any other byte disables it.
- R3: A write to 0x2000–0x2FFF loads the data byte into ROM bank bits 7:0 and keeps bit 8.
- R4: A write to 0x3000–0x3FFF loads ROM bank bit 8 from data bit 0, ignores data bits 7:1 and keeps bits 7:0.
- R5: A ROM bank value of 0 selects bank 0 in the switchable window. It is never remapped to bank 1.
- R6: A write to 0x4000–0x5FFF loads the RAM bank from data bits 3:0 and ignores bits 7:4. When RAM is configured absent, the RAM bank stays 0.
- R7: A read in 0x0000–0x3FFF drives rom_addr = addr[13:0] with rom_rd high. A read in 0x4000–0x7FFF drives rom_addr = bank·2^14 + addr[13:0] with rom_rd high.
- R8: A read in 0x4000–0x7FFF with the ROM bank at or above ROM_BANKS raises zero_data and keeps rom_rd low.
- R9: A write to 0xA000–0xBFFF raises ram_we with ram_addr = ram_bank·2^13 + addr[12:0] only when RAM is present and enabled and the bank is below RAM_BANKS. Otherwise ram_we stays low.
- R10: A read in 0xA000–0xBFFF raises ram_rd at the same address under the same conditions. Otherwise it raises zero_data with ram_rd low.
- R11: Writes to 0x6000–0x7FFF and to 0x8000 and above change no control state. Reads in 0x8000–0x9FFF and 0xC000–0xFFFF raise no strobe and no zero_data.
- R12: With cpu_rd low, zero_data, rom_rd and ram_rd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled at the rising edge for control writes |
| cpu_rd | input | 1 | CPU read strobe |
| rom_addr | output | 23 | Physical ROM byte address |
| rom_rd | output | 1 | ROM read enable |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_we | output | 1 | RAM write enable |
| ram_rd | output | 1 | RAM read enable |
| zero_data | output | 1 | The current read must return zero |

## Verification
The assertions assume that the CPU never raises cpu_rd and cpu_wr in the same cycle. They also assume that both strobes and the address are stable around the rising edge and carry no X after reset. The bench drives every access from a task that changes the address, data and strobe together at the falling edge and asserts only one strobe at a time. Combinational outputs are sampled one nanosecond after that edge. Control effects are sampled only after the following rising edge has passed.

// File: rtl/bank9_pkg.sv
package bank9_pkg;

   localparam int BANK_W      = 9;
   localparam int RAMB_W      = 4;
   localparam int ROM_OFS_W   = 14;
   localparam int RAM_OFS_W   = 13;
   localparam int ROM_AW      = BANK_W + ROM_OFS_W;
   localparam int RAM_AW      = RAMB_W + RAM_OFS_W;
   localparam logic [7:0] ENABLE_KEY = 8'h0A;

   typedef enum logic [2:0] {
      CTL_NONE,
      CTL_RAMEN,
      CTL_ROMLO,
      CTL_ROMHI,
      CTL_RAMBANK
   } ctl_sel_e;

   typedef enum logic [1:0] {
      WIN_NONE,
      WIN_ROM_FIXED,
      WIN_ROM_BANKED,
      WIN_RAM
   } win_e;

   function automatic ctl_sel_e ctl_decode(input logic [3:0] a_hi);
      case (a_hi)
         4'h0, 4'h1: ctl_decode = CTL_RAMEN;
         4'h2:       ctl_decode = CTL_ROMLO;
         4'h3:       ctl_decode = CTL_ROMHI;
         4'h4, 4'h5: ctl_decode = CTL_RAMBANK;
         default:    ctl_decode = CTL_NONE;
      endcase
   endfunction

   function automatic win_e win_decode(input logic [2:0] a_top);
      case (a_top)
         3'd0, 3'd1: win_decode = WIN_ROM_FIXED;
         3'd2, 3'd3: win_decode = WIN_ROM_BANKED;
         3'd5:       win_decode = WIN_RAM;
         default:    win_decode = WIN_NONE;
      endcase
   endfunction

endpackage

// File: rtl/bank9_ctrl_regs.sv
module bank9_ctrl_regs
   import bank9_pkg::*;
#(
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        addr_hi,
   input  logic [7:0]        wdata,
   input  logic              wr,
   output logic [BANK_W-1:0] rom_bank,
   output logic [RAMB_W-1:0] ram_bank,
   output logic              ram_en
);

   localparam int HI_W = BANK_W - 8;

   ctl_sel_e          sel;
   logic [BANK_W-1:0] rom_bank_q;
   logic [RAMB_W-1:0] ram_bank_q;
   logic              ram_en_q;

   assign sel = ctl_decode(addr_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rom_bank_q <= BANK_W'(1);
         ram_en_q   <= 1'b0;
      end else if (wr) begin
         case (sel)
            CTL_RAMEN: ram_en_q <= (wdata == ENABLE_KEY);
            CTL_ROMLO: rom_bank_q[7:0] <= wdata;
            CTL_ROMHI: rom_bank_q[BANK_W-1:8] <= wdata[HI_W-1:0];
            default: ;
         endcase
      end
   end

   generate
      if (RAM_PRESENT) begin : g_ram_bank
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ram_bank_q <= '0;
            else if (wr && sel == CTL_RAMBANK)
               ram_bank_q <= wdata[RAMB_W-1:0];
         end

         // R6
         ram_bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr_hi[3:1] == 3'b010) |=> (ram_bank_q == $past(wdata[RAMB_W-1:0])));
      end else begin : g_no_ram_bank
         assign ram_bank_q = '0;
      end
   endgenerate

   assign rom_bank = rom_bank_q;
   assign ram_bank = ram_bank_q;
   assign ram_en   = ram_en_q;

   // R2
   ram_enable_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr_hi[3:1] == 3'b000) |=> (ram_en_q == ($past(wdata) == 8'h0A)));

   // R3
   rom_lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr_hi == 4'h2) |=>
         (rom_bank_q[7:0] == $past(wdata) && rom_bank_q[BANK_W-1:8] == $past(rom_bank_q[BANK_W-1:8])));

   // R4
   rom_hi_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr_hi == 4'h3) |=>
         (rom_bank_q[7:0] == $past(rom_bank_q[7:0]) && rom_bank_q[8] == $past(wdata[0])));

   // R11
   ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr_hi >= 4'h6) |=> ($stable(rom_bank_q) && $stable(ram_en_q) && $stable(ram_bank_q)));

endmodule

// File: rtl/bank9_rom_map.sv
module bank9_rom_map
   import bank9_pkg::*;
#(
   parameter int ROM_BANKS = 320
) (
   input  logic [15:0]       addr,
   input  logic              rd,
   input  logic [BANK_W-1:0] bank,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_rd,
   output logic              rom_zero
);

   win_e win;
   logic bank_ok;
   logic [BANK_W-1:0] eff_bank;

   assign win      = win_decode(addr[15:13]);
   assign bank_ok  = (int'(bank) < ROM_BANKS);
   assign eff_bank = (win == WIN_ROM_BANKED) ? bank : '0;
   assign rom_addr = {eff_bank, addr[ROM_OFS_W-1:0]};

   always_comb begin
      rom_rd   = 1'b0;
      rom_zero = 1'b0;
      if (rd) begin
         case (win)
            WIN_ROM_FIXED:  rom_rd = 1'b1;
            WIN_ROM_BANKED: begin
               rom_rd   = bank_ok;
               rom_zero = !bank_ok;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/bank9_ram_map.sv
module bank9_ram_map
   import bank9_pkg::*;
#(
   parameter int RAM_BANKS   = 8,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic [15:0]       addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [RAMB_W-1:0] bank,
   input  logic              en,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   output logic              ram_rd,
   output logic              ram_zero
);

   logic in_win;
   logic usable;

   assign in_win   = (win_decode(addr[15:13]) == WIN_RAM);
   assign ram_addr = {bank, addr[RAM_OFS_W-1:0]};

   generate
      if (RAM_PRESENT) begin : g_ram
         assign usable = en && (int'(bank) < RAM_BANKS);
      end else begin : g_no_ram
         assign usable = 1'b0;
      end
   endgenerate

   assign ram_we   = wr && in_win && usable;
   assign ram_rd   = rd && in_win && usable;
   assign ram_zero = rd && in_win && !usable;

endmodule

// File: rtl/bank9_mapper.sv
module bank9_mapper
   import bank9_pkg::*;
#(
   parameter int ROM_BANKS   = 320,
   parameter int RAM_BANKS   = 8,
   parameter bit RAM_PRESENT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_wdata,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_rd,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_we,
   output logic              ram_rd,
   output logic              zero_data
);

   generate
      if (ROM_BANKS < 1 || ROM_BANKS > (1 << BANK_W)) begin : g_bad_rom
         $error("ROM_BANKS out of range for a 9-bit bank number");
      end
      if (RAM_BANKS < 1 || RAM_BANKS > (1 << RAMB_W)) begin : g_bad_ram
         $error("RAM_BANKS out of range for a 4-bit bank number");
      end
   endgenerate

   logic [BANK_W-1:0] rom_bank;
   logic [RAMB_W-1:0] ram_bank;
   logic              ram_en;
   logic              rom_zero;
   logic              ram_zero;

   bank9_ctrl_regs #(.RAM_PRESENT(RAM_PRESENT)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_hi  (cpu_addr[15:12]),
      .wdata    (cpu_wdata),
      .wr       (cpu_wr),
      .rom_bank (rom_bank),
      .ram_bank (ram_bank),
      .ram_en   (ram_en)
   );

   bank9_rom_map #(.ROM_BANKS(ROM_BANKS)) i_rom (
      .addr     (cpu_addr),
      .rd       (cpu_rd),
      .bank     (rom_bank),
      .rom_addr (rom_addr),
      .rom_rd   (rom_rd),
      .rom_zero (rom_zero)
   );

   bank9_ram_map #(.RAM_BANKS(RAM_BANKS), .RAM_PRESENT(RAM_PRESENT)) i_ram (
      .addr     (cpu_addr),
      .rd       (cpu_rd),
      .wr       (cpu_wr),
      .bank     (ram_bank),
      .en       (ram_en),
      .ram_addr (ram_addr),
      .ram_we   (ram_we),
      .ram_rd   (ram_rd),
      .ram_zero (ram_zero)
   );

   assign zero_data = rom_zero | ram_zero;

   // R8
   rom_zero_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_rd |-> !zero_data);

   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |-> (!zero_data && !rom_rd && !ram_rd));

   // R9
   ram_we_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b101 && ram_en));

endmodule

// File: tb/test_bank9_mapper.sv
`timescale 1ns/1ps
module test_bank9_mapper;

   localparam int ROM_BANKS = 320;
   localparam int RAM_BANKS = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [22:0] rom_addr;
   logic        rom_rd;
   logic [16:0] ram_addr;
   logic        ram_we;
   logic        ram_rd;
   logic        zero_data;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   bank9_mapper #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS), .RAM_PRESENT(1'b1)) i_bank9_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_addr(rom_addr), .rom_rd(rom_rd),
      .ram_addr(ram_addr), .ram_we(ram_we), .ram_rd(ram_rd), .zero_data(zero_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic do_rd(input logic [15:0] a);
      @(negedge clk);
      cpu_addr = a; cpu_wr = 1'b0; cpu_rd = 1'b1;
      #1;
   endtask

   task automatic probe_ram_wr(input logic [15:0] a, input logic [7:0] d,
                               input bit exp_we, input logic [16:0] exp_a, input string tag);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
      #1;
      chk(ram_we == exp_we, tag, ram_we, exp_we);
      if (exp_we) chk(ram_addr == exp_a, tag, ram_addr, exp_a);
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic expect_rom(input logic [15:0] a, input logic [8:0] bank, input string tag);
      logic [22:0] ea;
      ea = {bank, a[13:0]};
      do_rd(a);
      if (int'(bank) < ROM_BANKS) begin
         chk(rom_rd && !zero_data, tag, {rom_rd, zero_data}, 2'b10);
         chk(rom_addr == ea, tag, rom_addr, ea);
      end else begin
         chk(!rom_rd && zero_data, tag, {rom_rd, zero_data}, 2'b01);
      end
   endtask

   task automatic expect_ram_rd(input logic [15:0] a, input bit usable, input logic [3:0] bank, input string tag);
      logic [16:0] ea;
      ea = {bank, a[12:0]};
      do_rd(a);
      if (usable) begin
         chk(ram_rd && !zero_data, tag, {ram_rd, zero_data}, 2'b10);
         chk(ram_addr == ea, tag, ram_addr, ea);
      end else begin
         chk(!ram_rd && zero_data, tag, {ram_rd, zero_data}, 2'b01);
      end
   endtask

   task automatic t_reset;
      expect_rom(16'h4123, 9'd1, "R1 reset rom bank 1");
      expect_ram_rd(16'hA010, 1'b0, 4'd0, "R1 reset ram disabled");
      probe_ram_wr(16'hA010, 8'h55, 1'b0, '0, "R9 write while disabled");
   endtask

   task automatic t_fixed;
      do_rd(16'h1234);
      chk(rom_rd && rom_addr == 23'h1234, "R7 fixed window", rom_addr, 23'h1234);
      do_rd(16'h3FFF);
      chk(rom_addr == 23'h3FFF, "R7 fixed window top", rom_addr, 23'h3FFF);
   endtask

   task automatic t_rom_bank;
      do_wr(16'h2ABC, 8'h05);
      expect_rom(16'h4000, 9'h005, "R3 low byte");
      do_wr(16'h3F00, 8'h03);
      expect_rom(16'h7FFF, 9'h105, "R4 high bit set");
      do_wr(16'h2000, 8'h40);
      expect_rom(16'h5000, 9'h140, "R3 keeps bit 8 / R8 out of range");
      do_wr(16'h3000, 8'hFE);
      expect_rom(16'h6ABC, 9'h040, "R4 keeps low byte");
   endtask

   task automatic t_bank_zero;
      do_wr(16'h2000, 8'h00);
      expect_rom(16'h4555, 9'h000, "R5 bank zero kept");
   endtask

   task automatic t_enable;
      do_wr(16'h0000, 8'h0A);
      expect_ram_rd(16'hA000, 1'b1, 4'd0, "R2 enable key");
      do_wr(16'h1FFF, 8'h0B);
      expect_ram_rd(16'hA000, 1'b0, 4'd0, "R2 other byte disables");
      do_wr(16'h1000, 8'h0A);
      expect_ram_rd(16'hBFFF, 1'b1, 4'd0, "R2 re-enable");
   endtask

   task automatic t_ram_bank;
      do_wr(16'h4000, 8'hF3);
      expect_ram_rd(16'hBFFF, 1'b1, 4'd3, "R6 bank from low nibble / R10");
      probe_ram_wr(16'hA123, 8'h77, 1'b1, {4'd3, 13'h0123}, "R9 banked write");
      do_wr(16'h5FFF, 8'h0A);
      expect_ram_rd(16'hA000, 1'b0, 4'd10, "R10 bank out of range");
      probe_ram_wr(16'hA000, 8'h11, 1'b0, '0, "R9 out of range write dropped");
      do_wr(16'h4800, 8'h07);
      expect_ram_rd(16'hA042, 1'b1, 4'd7, "R6 last valid bank");
   endtask

   task automatic t_ignored;
      do_wr(16'h2000, 8'h21);
      do_wr(16'h6000, 8'hFF);
      do_wr(16'h7FFF, 8'h00);
      do_wr(16'h8000, 8'h00);
      do_wr(16'hC000, 8'h00);
      do_wr(16'hFFFF, 8'h00);
      expect_rom(16'h4001, 9'h021, "R11 rom bank unchanged");
      expect_ram_rd(16'hA001, 1'b1, 4'd7, "R11 ram state unchanged");
      probe_ram_wr(16'h4000, 8'h02, 1'b0, '0, "R11 control write no ram_we");
      do_rd(16'h9000);
      chk(!rom_rd && !ram_rd && !zero_data, "R11 unmapped read 0x9000", {rom_rd, ram_rd, zero_data}, 3'b000);
      do_rd(16'hE000);
      chk(!rom_rd && !ram_rd && !zero_data, "R11 unmapped read 0xE000", {rom_rd, ram_rd, zero_data}, 3'b000);
   endtask

   task automatic t_idle;
      do_wr(16'h0000, 8'h00);
      do_wr(16'h2000, 8'h50);
      do_wr(16'h3000, 8'h01);
      @(negedge clk);
      cpu_rd = 1'b0; cpu_addr = 16'hA000; #1;
      chk(!zero_data && !ram_rd && !rom_rd, "R12 idle ram window", {rom_rd, ram_rd, zero_data}, 3'b000);
      cpu_addr = 16'h4000; #1;
      chk(!zero_data && !ram_rd && !rom_rd, "R12 idle rom window", {rom_rd, ram_rd, zero_data}, 3'b000);
      expect_rom(16'h4000, 9'h150, "R8 bank 0x150 zero");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_fixed;
      t_rom_bank;
      t_bank_zero;
      t_enable;
      t_ram_bank;
      t_ignored;
      t_idle;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule